// File: doc/BRIEF.md
# Clocked Nonretriggerable One-Shot

This block is a synchronous monostable timer. When it sees its trigger input HIGH at a rising clock edge while idle, it raises a single output pulse. The pulse lasts a whole number of clock periods, and that number is the delay value captured at the start. A down counter times the pulse. The width depends only on the clock period and the captured delay, so a 1 kHz clock and a delay of 10 give a 10 ms pulse.

The trigger is judged only by its level at each clock edge. A glitch that rises and falls between two edges is never seen. While a pulse runs, the trigger is ignored: it neither stretches nor restarts the pulse. A synchronous reset can cut a pulse short at any time. A delay of zero produces no pulse. If the trigger is still HIGH when a pulse ends, a new pulse starts one idle cycle later.

Top module: `clk_oneshot`

## Requirements
- R1: With `rst_i` HIGH at a rising edge, `pulse_o` is LOW after that edge and stays LOW until a trigger is sampled with reset released.
- R2: When idle, a rising edge that samples `trig_i` HIGH with `delay_i` non-zero and `rst_i` LOW drives `pulse_o` HIGH right after that edge.
- R3: A pulse started with `delay_i` = D (1 <= D) stays HIGH for exactly D clock periods, then goes LOW.
- R4: Trigger activity during a pulse has no effect: the width is still the D captured at the start.
- R5: `delay_i` is captured only on the starting edge; changing it during a pulse does not alter that pulse's width.
- R6: Asserting `rst_i` during a pulse makes `pulse_o` LOW after the next rising edge, and no pulse follows while the trigger stays LOW.
- R7: Reset takes priority over the trigger: an edge with both `rst_i` and `trig_i` HIGH leaves `pulse_o` LOW.
- R8: A trigger sampled with `delay_i` = 0 produces no pulse.
- R9: If `trig_i` is held HIGH, each pulse of D periods is followed by exactly one LOW period, then a new pulse.
- R10: A trigger that rises and falls entirely between two rising edges is missed, and `pulse_o` stays LOW.
- R11: The largest delay, 2^DELAY_W-1, produces a pulse of exactly that many periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every action happens on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; ends any pulse |
| trig_i | input | 1 | Level-sensitive trigger, sampled at each rising edge |
| delay_i | input | DELAY_W | Pulse width in clock periods, captured when a pulse starts |
| pulse_o | output | 1 | Registered one-shot output |

## Verification
A wrong count or a lost state bit shows at the port as a pulse of the wrong width. It is visible on the first cycle where `pulse_o` differs from a reference that tracks the remaining periods. A controller that wrongly honours a trigger mid-pulse shows as a stretched pulse when that pulse ends. A missed reset shows one edge after `rst_i` rises. The bench compares `pulse_o` with the reference on every clock. Directed cases then measure the width of each pulse directly.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    OS_IDLE = 1'b0,
    OS_BUSY = 1'b1
  } os_state_t;
endpackage

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               load,
  input  logic               dec,
  input  logic [DELAY_W-1:0] load_val,
  output logic               last,
  output logic [DELAY_W-1:0] count
);
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign last  = (cnt_q == ONE);
  assign count = cnt_q;
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic delay_nz,
  input  logic last,
  output logic load,
  output logic dec,
  output logic busy
);
  os_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= OS_IDLE;
    end else begin
      case (st_q)
        OS_IDLE: if (trig && delay_nz) st_q <= OS_BUSY;
        OS_BUSY: if (last)             st_q <= OS_IDLE;
        default:                       st_q <= OS_IDLE;
      endcase
    end
  end

  always_comb begin
    load = !rst && (st_q == OS_IDLE) && trig && delay_nz;
    dec  = !rst && (st_q == OS_BUSY);
  end

  assign busy = (st_q == OS_BUSY);
endmodule

// File: rtl/clk_oneshot.sv
module clk_oneshot #(
  parameter int DELAY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               trig_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               pulse_o
);
  logic               load_w;
  logic               dec_w;
  logic               last_w;
  logic               busy_w;
  logic               delay_nz_w;
  logic [DELAY_W-1:0] cnt_w;

  assign delay_nz_w = |delay_i;

  oneshot_ctrl u_ctrl (
    .clk      (clk_i),
    .rst      (rst_i),
    .trig     (trig_i),
    .delay_nz (delay_nz_w),
    .last     (last_w),
    .load     (load_w),
    .dec      (dec_w),
    .busy     (busy_w)
  );

  oneshot_counter #(.DELAY_W(DELAY_W)) u_cnt (
    .clk      (clk_i),
    .clr      (rst_i),
    .load     (load_w),
    .dec      (dec_w),
    .load_val (delay_i),
    .last     (last_w),
    .count    (cnt_w)
  );

  assign pulse_o = busy_w;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
  parameter int DELAY_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               trig,
  input logic [DELAY_W-1:0] delay,
  input logic               pulse,
  input logic [DELAY_W-1:0] cnt
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!pulse && cnt == '0));

  // R2, R5: start captures delay
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!pulse && trig && delay != '0) |=> (pulse && cnt == $past(delay)));

  // R4: no restart while busy
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse && cnt != DELAY_W'(1)) |=> (pulse && cnt == $past(cnt) - DELAY_W'(1)));

  // R3: ends after the last period
  p_end_r3: assert property (@(posedge clk) disable iff (rst)
    (pulse && cnt == DELAY_W'(1)) |=> !pulse);

  // R8
  p_zero_delay_r8: assert property (@(posedge clk) disable iff (rst)
    (!pulse && delay == '0) |=> !pulse);

  // R3: counter and controller agree
  p_busy_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    pulse == (cnt != '0));
endmodule

bind clk_oneshot oneshot_checker #(.DELAY_W(DELAY_W)) u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .trig  (trig_i),
  .delay (delay_i),
  .pulse (pulse_o),
  .cnt   (cnt_w)
);

// File: tb/tb_clk_oneshot.sv
`timescale 1ns/1ps
module tb_clk_oneshot;
  localparam int DW = 8;
  localparam int MAXD = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic [DW-1:0] delay = '0;
  logic          pulse;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  int rem = 0;

  always #2 clk = ~clk;

  clk_oneshot #(.DELAY_W(DW)) dut (
    .clk_i(clk), .rst_i(rst), .trig_i(trig), .delay_i(delay), .pulse_o(pulse)
  );

  // reference: periods remaining in the current pulse
  always @(posedge clk) begin
    if (rst)           rem = 0;
    else if (rem == 0) begin if (trig && delay != 0) rem = int'(delay); end
    else               rem = rem - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) chk(pulse == (rem != 0), "R3 model compare", int'(pulse), int'(rem != 0));
  end

  // trig_mode 1 toggles trigger during the pulse; new_delay >= 0 changes delay mid-pulse
  task automatic fire(input int d, input int trig_mode, input int new_delay, output int w);
    @(negedge clk); delay = DW'(d); trig = 1'b1;
    @(negedge clk);
    w = 0;
    while (pulse && w < 400) begin
      w++;
      trig = (trig_mode == 1) ? w[0] : 1'b0;
      if (w == 2 && new_delay >= 0) delay = DW'(new_delay);
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(pulse == 1'b0, "R1 reset state", int'(pulse), 0);
    rst = 1'b0; cmp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(pulse == 1'b0, "R1 idle after reset", int'(pulse), 0);

    // R2, R3
    @(negedge clk); delay = 8'd5; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(pulse == 1'b1, "R2 rise after trigger edge", int'(pulse), 1);
    w = 1;
    while (pulse && w < 400) begin @(negedge clk); if (pulse) w++; end
    chk(w == 5, "R3 width D=5", w, 5);

    fire(1, 0, -1, w);   chk(w == 1, "R3 width D=1", w, 1);
    fire(MAXD, 0, -1, w); chk(w == MAXD, "R11 max width", w, MAXD);
    fire(7, 1, -1, w);   chk(w == 7, "R4 triggers ignored", w, 7);
    fire(6, 0, 2, w);    chk(w == 6, "R5 delay change ignored", w, 6);

    // R6
    @(negedge clk); delay = 8'd20; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulse == 1'b1, "R6 pulse running", int'(pulse), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(pulse == 1'b0, "R6 early end", int'(pulse), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(pulse == 1'b0, "R6 stays low", int'(pulse), 0);

    // R7
    delay = 8'd4; rst = 1'b1; trig = 1'b1;
    @(negedge clk);
    chk(pulse == 1'b0, "R7 reset beats trigger", int'(pulse), 0);
    rst = 1'b0; trig = 1'b0;
    @(negedge clk);

    // R8
    delay = 8'd0; trig = 1'b1;
    repeat (3) @(negedge clk);
    chk(pulse == 1'b0, "R8 zero delay", int'(pulse), 0);
    trig = 1'b0;
    @(negedge clk);

    // R9: held trigger, D=3 -> 1,1,1,0,1
    delay = 8'd3; trig = 1'b1;
    @(negedge clk); chk(pulse == 1'b1, "R9 first pulse p1", int'(pulse), 1);
    @(negedge clk); chk(pulse == 1'b1, "R9 first pulse p2", int'(pulse), 1);
    @(negedge clk); chk(pulse == 1'b1, "R9 first pulse p3", int'(pulse), 1);
    @(negedge clk); chk(pulse == 1'b0, "R9 one idle period", int'(pulse), 0);
    @(negedge clk); chk(pulse == 1'b1, "R9 restart", int'(pulse), 1);
    trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(pulse == 1'b0, "R9 back to idle", int'(pulse), 0);

    // R10: glitch between edges
    delay = 8'd5;
    @(posedge clk); #0.5 trig = 1'b1; #1 trig = 1'b0;
    @(negedge clk); chk(pulse == 1'b0, "R10 glitch missed", int'(pulse), 0);
    repeat (2) @(negedge clk);
    chk(pulse == 1'b0, "R10 still idle", int'(pulse), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule